// File: doc/BRIEF.md
# I2C Serial Memory Read Target

This block is an I2C target in front of a 256-byte memory held in flip-flops. The bus lines are open-drain and are sampled on the system clock. The block answers one device address, built from a fixed four-bit prefix and three strap inputs. It serves three kinds of read:

- **Current-address read:** returns the byte at the location held in a persistent pointer.
- **Random read:** the master first writes a single word-address byte with R/W = 0, then issues a repeated START and re-addresses the device with R/W = 1. The read returns the byte at that word address.
- **Sequential read:** each time the master acknowledges a data byte, the block streams the next location. The pointer wraps from the top location back to zero.

The pointer survives across transactions and advances by one after every byte sent. A read that follows another read therefore carries on where the last one stopped. A side port lets the surrounding logic preload the memory contents, for example from a boot image.

The block does not stretch the clock. It accepts no data-byte writes: a byte that follows the word address gets no acknowledge.

Top module: `i2c_mem_rd_target`

## Requirements
- R1: A device address byte whose upper seven bits equal 1010 followed by `strap[2:0]` (bit 0 being R/W) is acknowledged. The target pulls SDA low during the ninth clock.
- R2: A device address byte that does not match gets no acknowledge. SDA is not driven until the next START, and the pointer is not changed.
- R3: After reset `sda_oe` is 0 and the pointer is 0. A matched address with R/W = 1 returns the byte at the pointer, MSB first.
- R4: A device address with R/W = 0 followed by one word-address byte acknowledges both bytes and loads the pointer with the word address. A repeated START and R/W = 1 then return the byte at that word address.
- R5: The pointer advances by exactly one after each transmitted byte, including the last byte, which the master does not acknowledge. A later current-address read continues from the next location.
- R6: If the master acknowledges (SDA low) after a data byte, the target sends the byte from the next location.
- R7: During a sequential read, the pointer wraps from 255 to 0.
- R8: A master non-acknowledge followed by STOP leaves SDA released, and the next START is served normally.
- R9: A START in the middle of a byte abandons that byte and restarts device address reception, leaving the pointer untouched.
- R10: A STOP in the middle of a byte returns the target to idle without changing the pointer.
- R11: `sda_oe` changes only while SCL is low.
- R12: When `pre_we` is high on a clock edge, `pre_data` is written to location `pre_addr`, and bus reads return that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap | input | 3 | Low three bits of the device address |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | 8 | Preload location |
| pre_data | input | 8 | Preload byte |

## Verification
The bench aims at the pointer's persistence and its wrap:

- It reads across location 255. A pointer that saturates there, or fails to wrap, returns the wrong byte after the boundary.
- It runs current-address reads straight after non-acknowledged reads. A design that skips the increment on the last byte repeats a byte.

It also covers the cases where the bus should have no lasting effect:

- A foreign device address must leave the ack slot of the following byte high.
- A START or STOP cut in halfway through the word-address byte must leave the pointer untouched. A design that loads the pointer early would return data from a garbage location.

Random mixes of current, random and sequential reads over random preloaded data complete the picture.

// File: rtl/i2c_mem_rd_target.sv
module i2c_mem_rd_target #(
  parameter int          AW     = 8,
  parameter logic [3:0]  DEV_ID = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [2:0]    strap,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {IDLE, DEV, DACK, WADR, WACK, TX, MACK} st_t;

  logic [2:0]    scl_p, sda_p;
  st_t           st;
  logic [3:0]    bitn;
  logic [7:0]    sr, tx;
  logic          rw, more;
  logic [AW-1:0] ptr;
  logic [7:0]    mem [DEPTH];

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire dev_hit   = (sr[7:1] == {DEV_ID, strap});

  assign sda_oe = (st == DACK) || (st == WACK) || (st == TX && !tx[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk)
    if (pre_we) mem[pre_addr] <= pre_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st   <= IDLE;
      bitn <= '0;
      sr   <= '0;
      tx   <= '0;
      rw   <= 1'b0;
      more <= 1'b0;
      ptr  <= '0;
    end else if (start_det) begin
      st   <= DEV;
      bitn <= '0;
    end else if (stop_det) begin
      st <= IDLE;
    end else begin
      case (st)
        DEV, WADR: begin
          if (scl_rise && bitn < 4'd8) begin
            sr   <= {sr[6:0], sda_s};
            bitn <= bitn + 4'd1;
          end
          if (scl_fall && bitn == 4'd8) begin
            if (st == WADR) begin
              ptr <= sr[AW-1:0];
              st  <= WACK;
            end else if (dev_hit) begin
              rw <= sr[0];
              st <= DACK;
            end else begin
              st <= IDLE;
            end
          end
        end
        DACK: if (scl_fall) begin
          bitn <= '0;
          if (rw) begin
            tx <= mem[ptr];
            st <= TX;
          end else begin
            st <= WADR;
          end
        end
        WACK: if (scl_fall) st <= IDLE;
        TX: if (scl_fall) begin
          if (bitn == 4'd7) begin
            ptr <= ptr + 1'b1;
            st  <= MACK;
          end else begin
            tx   <= {tx[6:0], 1'b0};
            bitn <= bitn + 4'd1;
          end
        end
        MACK: begin
          if (scl_rise) more <= ~sda_s;
          else if (scl_fall) begin
            if (more) begin
              tx   <= mem[ptr];
              bitn <= '0;
              st   <= TX;
            end else begin
              st <= IDLE;
            end
          end
        end
        default: st <= IDLE;
      endcase
    end

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(!scl_s) || $past(start_det) || $past(stop_det)));

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_byte_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == TX && scl_fall && bitn == 4'd7 && !start_det && !stop_det)
      |=> ptr == AW'($past(ptr) + 1'b1));

  assert_miss_noack_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == DEV && scl_fall && bitn == 4'd8 && !dev_hit && !start_det && !stop_det)
      |=> !sda_oe);

  assert_idle_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |=> $stable(ptr));
endmodule

// File: tb/sim_i2c_mem_rd_target.sv
module sim_i2c_mem_rd_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 6;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, pre_we = 1'b0;
  logic [7:0] pre_addr = '0, pre_data = '0;
  wire sda_w = sda_m & ~sda_oe;

  int checks = 0, errors = 0, r11_bad = 0;
  logic oe_prev = 1'b0;
  logic [7:0] mdl_mem [256];
  logic [7:0] mdl_ptr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mem_rd_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
    .strap(STRAP), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data));

  always @(negedge clk) begin
    if (rst_n && scl_m && sda_oe !== oe_prev) r11_bad++;
    oe_prev = sda_oe;
  end

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    return mdl_mem[a];
  endfunction

  function automatic logic [7:0] dev_byte(input logic [2:0] s, input logic r);
    return {4'b1010, s, r};
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); sda_m = 1'b0; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; tick(); scl_m = 1'b1; tick(); tick(); scl_m = 1'b0; tick();
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); b = sda_w; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack_n);
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(ack_n);
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic master_ack);
    for (int i = 7; i >= 0; i--) rbit(v[i]);
    wbit(~master_ack);
  endtask

  task automatic read_body(input int n, input string tag);
    logic [7:0] got;
    for (int i = 0; i < n; i++) begin
      recv_byte(got, i < n - 1);
      check(got == exp_byte(mdl_ptr), tag, got, exp_byte(mdl_ptr));
      mdl_ptr = mdl_ptr + 8'd1;
    end
    i2c_stop();
  endtask

  task automatic cur_read(input int n, input string tag);
    logic a;
    i2c_start();
    send_byte(dev_byte(STRAP, 1'b1), a);
    check(a == 1'b0, "R1 read address ack", a, 0);
    read_body(n, tag);
  endtask

  task automatic rand_read(input logic [7:0] addr, input int n, input string tag);
    logic a;
    i2c_start();
    send_byte(dev_byte(STRAP, 1'b0), a);
    check(a == 1'b0, "R1 write address ack", a, 0);
    send_byte(addr, a);
    check(a == 1'b0, "R4 word address ack", a, 0);
    mdl_ptr = addr;
    i2c_start();
    send_byte(dev_byte(STRAP, 1'b1), a);
    check(a == 1'b0, "R4 repeated start ack", a, 0);
    read_body(n, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] got;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    check(sda_oe == 1'b0, "R3 reset sda_oe", sda_oe, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 256; i++) begin
      pre_we = 1'b1; pre_addr = 8'(i); pre_data = 8'($urandom);
      mdl_mem[i] = pre_data;
      @(negedge clk);
    end
    pre_we = 1'b0;
    tick();

    cur_read(1, "R3 current read from reset pointer 0");
    cur_read(2, "R5 current read continues after last");
    rand_read(8'h40, 1, "R4 random read");
    rand_read(8'h10, 4, "R6 sequential read");
    cur_read(1, "R5 current read after sequential");
    rand_read(8'hFE, 4, "R7 wrap 255 to 0");
    check(mdl_ptr == 8'h02, "R7 model pointer", mdl_ptr, 2);
    cur_read(1, "R8 read after nack and stop");
    check(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);

    i2c_start();
    send_byte(dev_byte(3'b011, 1'b1), a);
    check(a == 1'b1, "R2 foreign address nack", a, 1);
    send_byte(8'h00, a);
    check(a == 1'b1, "R2 no drive until start", a, 1);
    i2c_stop();
    cur_read(1, "R2 pointer unchanged after foreign address");

    i2c_start();
    send_byte(dev_byte(STRAP, 1'b0), a);
    for (int i = 0; i < 4; i++) wbit(1'b1);
    i2c_start();
    send_byte(dev_byte(STRAP, 1'b1), a);
    check(a == 1'b0, "R9 restart ack", a, 0);
    read_body(1, "R9 pointer unchanged after mid-byte start");

    i2c_start();
    send_byte(dev_byte(STRAP, 1'b0), a);
    for (int i = 0; i < 3; i++) wbit(1'b0);
    sda_m = 1'b0; tick();
    i2c_stop();
    check(sda_oe == 1'b0, "R10 idle after mid-byte stop", sda_oe, 0);
    cur_read(1, "R10 pointer unchanged after mid-byte stop");

    pre_we = 1'b1; pre_addr = 8'h77; pre_data = 8'hC3; mdl_mem[8'h77] = 8'hC3;
    @(negedge clk);
    pre_we = 1'b0;
    rand_read(8'h77, 1, "R12 preload visible on bus");

    for (int k = 0; k < 20; k++) begin
      int n;
      n = 1 + int'($urandom % 4);
      if ($urandom % 2 == 0) cur_read(n, "R5 random current read");
      else rand_read(8'($urandom), n, "R6 random sequential read");
    end

    i2c_start();
    send_byte(dev_byte(STRAP, 1'b1), a);
    recv_byte(got, 1'b0);
    check(got == exp_byte(mdl_ptr), "R3 final read", got, exp_byte(mdl_ptr));
    mdl_ptr = mdl_ptr + 8'd1;
    i2c_stop();

    check(r11_bad == 0, "R11 sda_oe changed with SCL high", r11_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule